// File: doc/BRIEF.md
# NAND Page Transfer Sequencer

This block turns one high-level request for a serial NAND device into the ordered series of frame descriptors that a separate frame engine shifts onto the wire. A request is a code for the kind of operation, plus a row (page or block) address, a column (byte within the cache) address, a transfer length and a chosen read mode. The block walks a short step list per request. It emits each command descriptor through a valid/ready handshake. Where the device must finish an internal array operation, it hands control to an external status-poll block and waits until that block reports the device idle together with its status byte.

The flows follow the device's array-plus-cache model. A page read moves the page from the array into the cache, waits, then streams from the cache. A program fills the cache first, then commits it to the array, with a write enable placed just before the commit. An erase is a write enable followed by the block erase command. Reset, identification and two feature-register writes (block unlock and configuration) finish the set. When the list is done, the block raises a one-cycle result carrying success, failure or the ECC outcome that the poll status reported.

Top module: `nand_seq`

## Requirements
- R1: Request codes are 0 page read, 1 program with cache reset, 2 program with partial cache update, 3 block erase, 4 device reset, 5 identify, 6 unlock all blocks, 7 write configuration. `req_ready` is high only when idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from acceptance until the cycle after the result, and anything offered meanwhile is ignored and produces no descriptor.
- R2: A page read emits opcode 0x13 carrying the row in 3 address bytes, then holds `poll_req` until `poll_done`, then emits the cache-read descriptor carrying the column in 2 address bytes, input direction and the requested length. Direction codes are 0 none, 1 data in, 2 data out. Commands with no data use direction 0, length 0, 1 lane and no dummy bytes.
- R3: Read mode selects the cache-read opcode, dummy bytes and data lanes: 0 → 0x03/0/1, 1 → 0x0B/1/1, 2 → 0x3B/1/2, 3 → 0x6B/1/4, 4 → 0xBB/1/2, 5 → 0xEB/2/4. Modes 6 and 7 behave as mode 0.
- R4: A program first loads the cache (code 1: 0x02, or 0x32 when the mode is 3 or 5; code 2: 0x84, or 0x34 in those modes), using the column in 2 bytes, data out, the request length, and 4 lanes in the quad modes or 1 otherwise. It then emits write enable 0x06, then 0x10 with the row in 3 bytes, then polls.
- R5: An erase emits 0x06, then 0xD8 with the row in 3 bytes, then polls. No 0x10 or 0xD8 descriptor is ever accepted unless the previous accepted descriptor was 0x06.
- R6: A device reset emits 0xFF with no address, then polls.
- R7: Identify emits one 0x9F descriptor, data in on 1 lane. The form input selects 0 nothing extra, 1 one address byte of value 0, or 2 one dummy byte. The length is the request length when it lies from 1 to 4, and 4 otherwise. No poll follows.
- R8: Unlock emits 0x1F to feature address 0xA0 with one outgoing byte of 0x00. Write configuration emits 0x1F to 0xB0 with one outgoing byte whose bit 4 (ECC enable) is set and whose bit 0 (quad enable) equals whether the mode is 3 or 5. Both carry 1 address byte.
- R9: Result codes are 0 success, 1 failure, 2 ECC corrected, 3 ECC uncorrectable. Status bits [5:4] decide a read: 0 gives 0, 1 gives 2, and any other value gives 3. Status bit 3 gives failure for either program. Status bit 2 gives failure for an erase. All other requests report 0. `res_valid` lasts exactly one cycle.
- R10: While `desc_valid` is high and `desc_ready` is low, the descriptor stays valid and unchanged.
- R11: During and right after reset, `req_ready` is high and `desc_valid`, `poll_req` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_code | input | 3 | Operation code |
| req_row | input | ROW_W | Page or block address |
| req_col | input | COL_W | Byte offset in the cache |
| req_len | input | LEN_W | Data length in bytes |
| req_mode | input | 3 | Read mode, also picks quad loads |
| req_id_form | input | 2 | Identify form |
| desc_valid | output | 1 | Descriptor offered to the frame engine |
| desc_ready | input | 1 | Frame engine takes the descriptor |
| desc_opcode | output | 8 | Command byte |
| desc_addr | output | ROW_W | Address value |
| desc_addr_bytes | output | 2 | Number of address bytes |
| desc_dummy_bytes | output | 2 | Number of dummy bytes |
| desc_lanes | output | 3 | Data lanes |
| desc_dir | output | 2 | Data direction code |
| desc_len | output | LEN_W | Data byte count |
| desc_wdata | output | 8 | Single outgoing byte for feature writes |
| poll_req | output | 1 | Ask the poll block to wait for ready |
| poll_done | input | 1 | Poll finished, status valid |
| poll_status | input | 8 | Device status byte at poll end |
| res_valid | output | 1 | Result pulse |
| res_code | output | 2 | Result code |

## Verification
The assertions take for granted that the poll block raises `poll_done` only while `poll_req` is high and for a single cycle, and that the frame engine may stall for any number of cycles. The bench's poll responder answers only after seeing `poll_req` for three cycles and drops `poll_done` the next cycle. The ready line toggles pseudo-randomly in the backpressure runs. The request fields are only sampled at acceptance, so the bench drives them with the valid and also fires a rogue request while the block is busy to show that it is dropped.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [2:0] {
    RQ_READ   = 3'd0,
    RQ_PROG   = 3'd1,
    RQ_UPDATE = 3'd2,
    RQ_ERASE  = 3'd3,
    RQ_RESET  = 3'd4,
    RQ_IDENT  = 3'd5,
    RQ_UNLOCK = 3'd6,
    RQ_CONFIG = 3'd7
  } req_e;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_POLL = 2'd1,
    K_END  = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    D_NONE = 2'd0,
    D_IN   = 2'd1,
    D_OUT  = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    RS_OK    = 2'd0,
    RS_FAIL  = 2'd1,
    RS_FIXED = 2'd2,
    RS_LOST  = 2'd3
  } res_e;

  function automatic logic [7:0] cache_read_op(input logic [2:0] mode);
    case (mode)
      3'd1:    return 8'h0B;
      3'd2:    return 8'h3B;
      3'd3:    return 8'h6B;
      3'd4:    return 8'hBB;
      3'd5:    return 8'hEB;
      default: return 8'h03;
    endcase
  endfunction

  function automatic logic [1:0] cache_read_dummy(input logic [2:0] mode);
    if (mode == 3'd5) return 2'd2;
    if (mode >= 3'd1 && mode <= 3'd4) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic quad_mode(input logic [2:0] mode);
    return (mode == 3'd3) || (mode == 3'd5);
  endfunction

  function automatic logic [2:0] cache_read_lanes(input logic [2:0] mode);
    if (quad_mode(mode)) return 3'd4;
    if (mode == 3'd2 || mode == 3'd4) return 3'd2;
    return 3'd1;
  endfunction

endpackage

// File: rtl/nseq_step.sv
module nseq_step
  import nseq_pkg::*;
#(
  parameter int ROW_W  = 24,
  parameter int COL_W  = 16,
  parameter int LEN_W  = 13,
  parameter int STEP_W = 3,
  parameter int ID_MAX = 4
) (
  input  req_e              req,
  input  logic [2:0]        mode,
  input  logic [1:0]        id_form,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [LEN_W-1:0]  len,
  input  logic [STEP_W-1:0] idx,
  output kind_e             kind,
  output logic [7:0]        op,
  output logic [ROW_W-1:0]  addr,
  output logic [1:0]        abytes,
  output logic [1:0]        dummy,
  output logic [2:0]        lanes,
  output dir_e              dir,
  output logic [LEN_W-1:0]  dlen,
  output logic [7:0]        wdata
);
  localparam logic [LEN_W-1:0] ID_CAP = LEN_W'(ID_MAX);

  logic [ROW_W-1:0] col_ext;
  logic             quad;
  assign col_ext = ROW_W'(col);
  assign quad    = quad_mode(mode);

  always_comb begin
    kind   = K_END;
    op     = 8'h00;
    addr   = '0;
    abytes = 2'd0;
    dummy  = 2'd0;
    lanes  = 3'd1;
    dir    = D_NONE;
    dlen   = '0;
    wdata  = 8'h00;
    case (req)
      RQ_READ: begin
        if (idx == 0) begin
          kind = K_CMD; op = 8'h13; addr = row; abytes = 2'd3;
        end else if (idx == 1) begin
          kind = K_POLL;
        end else if (idx == 2) begin
          kind = K_CMD; op = cache_read_op(mode); addr = col_ext;
          abytes = 2'd2; dummy = cache_read_dummy(mode);
          lanes = cache_read_lanes(mode); dir = D_IN; dlen = len;
        end
      end
      RQ_PROG, RQ_UPDATE: begin
        if (idx == 0) begin
          kind = K_CMD; addr = col_ext; abytes = 2'd2; dir = D_OUT; dlen = len;
          lanes = quad ? 3'd4 : 3'd1;
          if (req == RQ_PROG) op = quad ? 8'h32 : 8'h02;
          else                op = quad ? 8'h34 : 8'h84;
        end else if (idx == 1) begin
          kind = K_CMD; op = 8'h06;
        end else if (idx == 2) begin
          kind = K_CMD; op = 8'h10; addr = row; abytes = 2'd3;
        end else if (idx == 3) begin
          kind = K_POLL;
        end
      end
      RQ_ERASE: begin
        if (idx == 0) begin
          kind = K_CMD; op = 8'h06;
        end else if (idx == 1) begin
          kind = K_CMD; op = 8'hD8; addr = row; abytes = 2'd3;
        end else if (idx == 2) begin
          kind = K_POLL;
        end
      end
      RQ_RESET: begin
        if (idx == 0) begin
          kind = K_CMD; op = 8'hFF;
        end else if (idx == 1) begin
          kind = K_POLL;
        end
      end
      RQ_IDENT: begin
        if (idx == 0) begin
          kind = K_CMD; op = 8'h9F; dir = D_IN;
          dlen = (len == '0 || len > ID_CAP) ? ID_CAP : len;
          if (id_form == 2'd1) abytes = 2'd1;
          if (id_form == 2'd2) dummy  = 2'd1;
        end
      end
      RQ_UNLOCK, RQ_CONFIG: begin
        if (idx == 0) begin
          kind = K_CMD; op = 8'h1F; abytes = 2'd1; dir = D_OUT; dlen = LEN_W'(1);
          addr = (req == RQ_UNLOCK) ? ROW_W'(8'hA0) : ROW_W'(8'hB0);
          wdata = (req == RQ_UNLOCK) ? 8'h00 : {3'b000, 1'b1, 3'b000, quad};
        end
      end
      default: kind = K_END;
    endcase
  end
endmodule

// File: rtl/nseq_verdict.sv
module nseq_verdict
  import nseq_pkg::*;
(
  input  req_e       req,
  input  logic [5:2] flags,
  output res_e       verdict
);
  always_comb begin
    verdict = RS_OK;
    case (req)
      RQ_READ: begin
        case (flags[5:4])
          2'b00:   verdict = RS_OK;
          2'b01:   verdict = RS_FIXED;
          default: verdict = RS_LOST;
        endcase
      end
      RQ_PROG, RQ_UPDATE: verdict = flags[3] ? RS_FAIL : RS_OK;
      RQ_ERASE:           verdict = flags[2] ? RS_FAIL : RS_OK;
      default:            verdict = RS_OK;
    endcase
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nseq_pkg::*;
#(
  parameter int ROW_W  = 24,
  parameter int COL_W  = 16,
  parameter int LEN_W  = 13,
  parameter int ID_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_code,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic [2:0]       req_mode,
  input  logic [1:0]       req_id_form,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic [7:0]       desc_opcode,
  output logic [ROW_W-1:0] desc_addr,
  output logic [1:0]       desc_addr_bytes,
  output logic [1:0]       desc_dummy_bytes,
  output logic [2:0]       desc_lanes,
  output logic [1:0]       desc_dir,
  output logic [LEN_W-1:0] desc_len,
  output logic [7:0]       desc_wdata,
  output logic             poll_req,
  input  logic             poll_done,
  input  logic [7:0]       poll_status,
  output logic             res_valid,
  output logic [1:0]       res_code
);
  localparam int STEP_W = 3;

  logic             busy_q;
  req_e             req_q;
  logic [2:0]       mode_q;
  logic [1:0]       form_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] len_q;
  logic [STEP_W-1:0] idx_q;
  logic [5:2]       flags_q;

  kind_e kind;
  dir_e  dir;
  res_e  verdict;

  logic accept, desc_fire, poll_fire, finish;

  nseq_step #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .STEP_W(STEP_W), .ID_MAX(ID_MAX)
  ) u_step (
    .req(req_q), .mode(mode_q), .id_form(form_q), .row(row_q), .col(col_q),
    .len(len_q), .idx(idx_q), .kind(kind), .op(desc_opcode), .addr(desc_addr),
    .abytes(desc_addr_bytes), .dummy(desc_dummy_bytes), .lanes(desc_lanes),
    .dir(dir), .dlen(desc_len), .wdata(desc_wdata)
  );

  nseq_verdict u_verdict (.req(req_q), .flags(flags_q), .verdict(verdict));

  assign req_ready  = !busy_q;
  assign accept     = req_valid && req_ready;
  assign desc_valid = busy_q && (kind == K_CMD);
  assign poll_req   = busy_q && (kind == K_POLL);
  assign res_valid  = busy_q && (kind == K_END);
  assign desc_fire  = desc_valid && desc_ready;
  assign poll_fire  = poll_req && poll_done;
  assign finish     = res_valid;
  assign desc_dir   = dir;
  assign res_code   = verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      req_q   <= RQ_READ;
      mode_q  <= '0;
      form_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      flags_q <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      req_q   <= req_e'(req_code);
      mode_q  <= req_mode;
      form_q  <= req_id_form;
      row_q   <= req_row;
      col_q   <= req_col;
      len_q   <= req_len;
      idx_q   <= '0;
      flags_q <= '0;
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (desc_fire || poll_fire) begin
      idx_q <= idx_q + 1'b1;
      if (poll_fire) flags_q <= poll_status[5:2];
    end
  end

  // Checks next to the control they guard
  logic [7:0] last_op_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_op_q <= 8'h00;
    else if (desc_fire) last_op_q <= desc_opcode;
  end

  p_busy_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid || poll_req || res_valid) |-> !req_ready);

  p_free_after_res_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> req_ready);

  p_poll_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && !poll_done) |=> poll_req);

  p_wren_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_fire && (desc_opcode == 8'h10 || desc_opcode == 8'hD8)) |-> (last_op_q == 8'h06));

  p_res_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_hold_desc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_opcode) &&
      $stable(desc_addr) && $stable(desc_len) && $stable(desc_wdata)));
endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_code = '0;
  logic [23:0] req_row = '0;
  logic [15:0] req_col = '0;
  logic [12:0] req_len = '0;
  logic [2:0]  req_mode = '0;
  logic [1:0]  req_id_form = '0;
  logic        desc_valid;
  logic        desc_ready = 1'b1;
  logic [7:0]  desc_opcode;
  logic [23:0] desc_addr;
  logic [1:0]  desc_addr_bytes, desc_dummy_bytes, desc_dir;
  logic [2:0]  desc_lanes;
  logic [12:0] desc_len;
  logic [7:0]  desc_wdata;
  logic        poll_req;
  logic        poll_done = 1'b0;
  logic [7:0]  poll_status = '0;
  logic        res_valid;
  logic [1:0]  res_code;

  nand_seq u_nand_seq (.*);

  int checks = 0, errors = 0, res_seen = 0;
  logic [61:0] exp_q[$];
  logic [1:0]  res_q[$];
  logic [7:0]  tb_status = '0;
  bit          bp_en = 1'b0;
  logic [7:0]  lfsr = 8'h5A;

  function automatic logic [61:0] pk(input logic [7:0] op, input logic [23:0] a,
      input logic [1:0] ab, input logic [1:0] dm, input logic [2:0] ln,
      input logic [1:0] dr, input logic [12:0] l, input logic [7:0] wd);
    return {op, a, ab, dm, ln, dr, l, wd};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_req(input logic [2:0] code, input logic [23:0] row,
      input logic [15:0] col, input logic [12:0] len, input logic [2:0] mode,
      input logic [1:0] form, input logic [7:0] st);
    logic [7:0] rop [8] = '{8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'h03, 8'h03};
    logic [1:0] rdm [8] = '{2'd0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd0, 2'd0};
    logic [2:0] rln [8] = '{3'd1, 3'd1, 3'd2, 3'd4, 3'd2, 3'd4, 3'd1, 3'd1};
    bit q;
    logic [12:0] il;
    q = (mode == 3) || (mode == 5);
    case (code)
      3'd0: begin
        exp_q.push_back(pk(8'h13, row, 3, 0, 1, 0, 0, 0));
        exp_q.push_back(pk(rop[mode], {8'h00, col}, 2, rdm[mode], rln[mode], 1, len, 0));
        res_q.push_back(st[5:4] == 0 ? 2'd0 : (st[5:4] == 1 ? 2'd2 : 2'd3));
      end
      3'd1, 3'd2: begin
        exp_q.push_back(pk(code == 1 ? (q ? 8'h32 : 8'h02) : (q ? 8'h34 : 8'h84),
                           {8'h00, col}, 2, 0, q ? 3'd4 : 3'd1, 2, len, 0));
        exp_q.push_back(pk(8'h06, 0, 0, 0, 1, 0, 0, 0));
        exp_q.push_back(pk(8'h10, row, 3, 0, 1, 0, 0, 0));
        res_q.push_back(st[3] ? 2'd1 : 2'd0);
      end
      3'd3: begin
        exp_q.push_back(pk(8'h06, 0, 0, 0, 1, 0, 0, 0));
        exp_q.push_back(pk(8'hD8, row, 3, 0, 1, 0, 0, 0));
        res_q.push_back(st[2] ? 2'd1 : 2'd0);
      end
      3'd4: begin
        exp_q.push_back(pk(8'hFF, 0, 0, 0, 1, 0, 0, 0));
        res_q.push_back(2'd0);
      end
      3'd5: begin
        il = (len == 0 || len > 4) ? 13'd4 : len;
        exp_q.push_back(pk(8'h9F, 0, form == 1 ? 2'd1 : 2'd0, form == 2 ? 2'd1 : 2'd0, 1, 1, il, 0));
        res_q.push_back(2'd0);
      end
      3'd6: begin
        exp_q.push_back(pk(8'h1F, 24'hA0, 1, 0, 1, 2, 1, 8'h00));
        res_q.push_back(2'd0);
      end
      default: begin
        exp_q.push_back(pk(8'h1F, 24'hB0, 1, 0, 1, 2, 1, q ? 8'h11 : 8'h10));
        res_q.push_back(2'd0);
      end
    endcase
  endtask

  // ready driver for the frame-engine side
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    desc_ready = bp_en ? lfsr[0] : 1'b1;
  end

  // poll responder: answers after three cycles of poll_req, one-cycle done
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      poll_status = tb_status;
      if (poll_done) begin
        poll_done = 1'b0;
        cnt = 0;
      end else if (poll_req) begin
        cnt++;
        if (cnt >= 3) poll_done = 1'b1;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    bit stall_prev = 1'b0;
    logic [61:0] stall_word = '0;
    logic [61:0] cur, e;
    logic [1:0] er;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        cur = pk(desc_opcode, desc_addr, desc_addr_bytes, desc_dummy_bytes,
                 desc_lanes, desc_dir, desc_len, desc_wdata);
        if (stall_prev)
          check(desc_valid && cur == stall_word, "R10 stalled descriptor held", cur, stall_word);
        stall_prev = desc_valid && !desc_ready;
        stall_word = cur;
        if (desc_valid && desc_ready) begin
          if (exp_q.size() == 0) check(1'b0, "R1 unexpected descriptor", cur, 0);
          else begin
            e = exp_q.pop_front();
            check(cur == e, "descriptor R2 R3 R4 R5 R6 R7 R8", cur, e);
          end
        end
        if (res_valid) begin
          if (res_q.size() == 0) check(1'b0, "R1 unexpected result", res_code, 0);
          else begin
            er = res_q.pop_front();
            check(res_code == er, "R9 result code", res_code, er);
          end
          res_seen++;
        end
      end
    end
  end

  task automatic run_req(input logic [2:0] code, input logic [23:0] row,
      input logic [15:0] col, input logic [12:0] len, input logic [2:0] mode,
      input logic [1:0] form, input logic [7:0] st, input bit inject);
    int n;
    expect_req(code, row, col, len, mode, form, st);
    tb_status = st;
    n = res_seen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_code = code; req_row = row; req_col = col; req_len = len;
    req_mode = mode; req_id_form = form; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      req_code = 3'd3; req_row = 24'hFFFFFF; req_valid = 1'b1;
      check(!req_ready, "R1 ready low while busy", req_ready, 0);
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    while (res_seen == n) @(negedge clk);
    check(req_ready, "R1 ready back after result", req_ready, 1);
    check(exp_q.size() == 0 && res_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R11 ready in reset", req_ready, 1);
    check(!desc_valid && !poll_req && !res_valid, "R11 outputs quiet in reset",
          {desc_valid, poll_req, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !desc_valid, "R11 idle after reset", {req_ready, desc_valid}, 2);

    // R2 R3 R9: every read mode, ECC outcomes
    run_req(0, 24'h012345, 16'h0040, 13'd2048, 0, 0, 8'h00, 1'b1);
    run_req(0, 24'h000001, 16'h0000, 13'd16,   1, 0, 8'h10, 1'b0);
    run_req(0, 24'h00ABCD, 16'h0800, 13'd64,   2, 0, 8'h20, 1'b0);
    run_req(0, 24'h7F0000, 16'h0123, 13'd1,    3, 0, 8'h30, 1'b0);
    run_req(0, 24'h000200, 16'h0004, 13'd8,    4, 0, 8'h00, 1'b0);
    run_req(0, 24'h000300, 16'h0010, 13'd4096, 5, 0, 8'h10, 1'b0);
    run_req(0, 24'h000400, 16'h0002, 13'd3,    6, 0, 8'h00, 1'b0);
    // R4 R5 R9 with backpressure (R10)
    bp_en = 1'b1;
    run_req(1, 24'h001000, 16'h0000, 13'd2112, 0, 0, 8'h08, 1'b0);
    run_req(1, 24'h001040, 16'h0000, 13'd512,  5, 0, 8'h00, 1'b0);
    run_req(2, 24'h001080, 16'h0100, 13'd32,   3, 0, 8'h00, 1'b1);
    run_req(2, 24'h0010C0, 16'h0200, 13'd7,    1, 0, 8'h08, 1'b0);
    run_req(3, 24'h002000, 16'h0000, 13'd0,    0, 0, 8'h00, 1'b0);
    run_req(3, 24'h002040, 16'h0000, 13'd0,    0, 0, 8'h04, 1'b0);
    // R6 R7 R8
    run_req(4, 24'h0, 16'h0, 13'd0, 0, 0, 8'h3C, 1'b0);
    run_req(5, 24'h0, 16'h0, 13'd2, 0, 0, 8'h00, 1'b0);
    run_req(5, 24'h0, 16'h0, 13'd0, 0, 1, 8'h00, 1'b0);
    run_req(5, 24'h0, 16'h0, 13'd7, 0, 2, 8'h00, 1'b0);
    bp_en = 1'b0;
    run_req(6, 24'h0, 16'h0, 13'd0, 0, 0, 8'h00, 1'b0);
    run_req(7, 24'h0, 16'h0, 13'd0, 0, 0, 8'h00, 1'b0);
    run_req(7, 24'h0, 16'h0, 13'd0, 3, 0, 8'h00, 1'b0);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule